// File: doc/BRIEF.md
# Lockable Watchdog Reset Timer

This block is a watchdog that counts down from firmware-chosen values and sends out a one-cycle reset request when it runs out. Firmware must refresh it in time to avoid that reset. Firmware can also load a very short count on purpose to force a chip reset. The count is built from three stages in a chain. A source tick is taken either from every clock or from an external timer tick input. A prescaler divides that tick, a pre-counter divides it again, and the main down-counter raises the request when it steps from one to zero.

The configuration can only change while the timer is halted. Halting it needs an exact three-byte key written to the key register. A reload command restarts the counters, and its flag reads back as set until the new values have been taken. A sticky reset-cause flag records every expiry. A system reset does not clear it, so firmware can read it after the reset that the watchdog caused. Only the power-on reset, or writing a one to the flag, clears it.

Top module: `wdog_timer`

## Requirements
- R1: After either reset the timer is running. Register reads are combinational by address: 0 reads the clock-source bit in bit 0 (reset 0); 1 reads the prescaler ratio (reset 0); 2 reads the pre-counter reload (reset 0xFF); 3 reads the main reload (reset 0xFF); 4 reads control, with bit 0 the reload-pending flag and bit 1 the reset-cause flag (reset 0); 5 reads 1 in bit 0 while halted; 6 reads the live main count; 7 reads zero.
- R2: Three writes to address 5 carrying 0x87, then 0x61, then 0x63, with no other write between them, halt the timer.
- R3: Any write that is not the next expected key byte, including a write to any other address, sends the key sequencer back to its start, and the timer keeps running.
- R4: Writes to addresses 0 to 3 take effect only while the timer is halted. While it runs they are ignored.
- R5: Writing 1 to bit 0 of address 4 sets reload-pending, which reads 1 in the following cycle. At the next edge the prescaler is cleared, both counters take their reload values, the flag reads 0 again, and the timer runs (and is locked). A refresh repeated before expiry prevents any reset request.
- R6: The source tick is every clock when configuration bit 0 is 0, and each high cycle of `tickIn` when it is 1. Expiry comes (P+1)*(Q+1)*M source ticks after the load, where P is the prescaler ratio, Q the pre-counter reload and M the main reload. With P=0, Q=0, M=1 and the clock source, `resetReq` is high in the second cycle after the reload write edge.
- R7: `resetReq` is high for exactly one cycle per expiry. The main count then stays at 0 and no further request is made until a reload. A main reload of 0 never expires.
- R8: Each expiry sets the reset-cause flag in the same cycle as the request. The flag survives `sysRst_n`. It is cleared by `porRst_n` or by writing 1 to bit 1 of address 4, and an expiry in the same cycle as that write wins.
- R9: Writing 0 to address 0 while halted returns the clock source to its default, every clock.
- R10: While halted the counters hold their values and no reset request is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| porRst_n | input | 1 | Power-on reset, active low, clears everything |
| sysRst_n | input | 1 | System reset, active low, keeps the reset-cause flag |
| wrEn | input | 1 | Register write strobe |
| addr | input | 3 | Register address for reads and writes |
| wrData | input | DW (8) | Write data |
| tickIn | input | 1 | External timer tick, one cycle per tick |
| rdData | output | DW (8) | Read data for `addr` |
| resetReq | output | 1 | One-cycle reset request on expiry |
| rstStatus | output | 1 | Sticky reset-cause flag |

## Verification
Register writes land at the clock edge that samples them, and reads are combinational, so a register read-back is due in the cycle after the write. The reload-pending flag reads 1 one cycle after the write and 0 one cycle later. `resetReq` and the reset-cause flag both appear one cycle after the edge of the final source tick, which is two cycles after the reload write in the fastest case. The bench keeps a behavioural model that advances on each rising edge and compares both outputs at every falling edge. Reads are checked at falling edges, and expiry times are measured by counting falling edges from the write, so every result is sampled in the cycle it is due.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int AW = 3;
  localparam int KEY_LEN = 3;

  localparam logic [AW-1:0] A_CFG  = 3'd0;
  localparam logic [AW-1:0] A_PSC  = 3'd1;
  localparam logic [AW-1:0] A_PRE  = 3'd2;
  localparam logic [AW-1:0] A_MAIN = 3'd3;
  localparam logic [AW-1:0] A_CTRL = 3'd4;
  localparam logic [AW-1:0] A_KEY  = 3'd5;
  localparam logic [AW-1:0] A_LIVE = 3'd6;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic run;
    logic useTick;
  } wdStrobe_t;

  function automatic logic [7:0] keyAt(input logic [1:0] idx);
    case (idx)
      2'd0:    return 8'h87;
      2'd1:    return 8'h61;
      default: return 8'h63;
    endcase
  endfunction
endpackage

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int DW       = 8,
  parameter int PRE_DEF  = 255,
  parameter int MAIN_DEF = 255
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          porRst_n,
  input  logic          wrEn,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wrData,
  input  logic          expire,
  input  logic [DW-1:0] liveMain,
  output wdStrobe_t     strb,
  output logic [DW-1:0] prescVal,
  output logic [DW-1:0] preRl,
  output logic [DW-1:0] mainRl,
  output logic          stopped,
  output logic          pending,
  output logic          statusFlag,
  output logic [DW-1:0] rdData
);
  localparam int SW = $clog2(KEY_LEN);

  logic [SW-1:0] seq;
  logic          useTick;
  logic          keyHit, reloadWr, clearWr, cfgWr;

  assign keyHit   = wrEn && (addr == A_KEY) && (wrData == DW'(keyAt(2'(seq))));
  assign reloadWr = wrEn && (addr == A_CTRL) && wrData[0];
  assign clearWr  = wrEn && (addr == A_CTRL) && wrData[1];
  assign cfgWr    = wrEn && stopped;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seq      <= '0;
      stopped  <= 1'b0;
      pending  <= 1'b0;
      useTick  <= 1'b0;
      prescVal <= '0;
      preRl    <= DW'(PRE_DEF);
      mainRl   <= DW'(MAIN_DEF);
    end else begin
      pending <= reloadWr;
      if (wrEn) begin
        if (keyHit) begin
          if (seq == SW'(KEY_LEN - 1)) begin
            seq     <= '0;
            stopped <= 1'b1;
          end else begin
            seq <= seq + 1'b1;
          end
        end else begin
          seq <= '0;
        end
      end
      if (reloadWr) stopped <= 1'b0;
      if (cfgWr) begin
        case (addr)
          A_CFG:   useTick  <= wrData[0];
          A_PSC:   prescVal <= wrData;
          A_PRE:   preRl    <= wrData;
          A_MAIN:  mainRl   <= wrData;
          default: ;
        endcase
      end
    end
  end

  // reset-cause flag: only the power-on reset touches it
  always_ff @(posedge clk or negedge porRst_n) begin
    if (!porRst_n)     statusFlag <= 1'b0;
    else if (expire)   statusFlag <= 1'b1;
    else if (clearWr)  statusFlag <= 1'b0;
  end

  assign strb.load    = pending;
  assign strb.run     = !stopped;
  assign strb.useTick = useTick;

  always_comb begin
    rdData = '0;
    case (addr)
      A_CFG:   rdData[0]   = useTick;
      A_PSC:   rdData      = prescVal;
      A_PRE:   rdData      = preRl;
      A_MAIN:  rdData      = mainRl;
      A_CTRL:  rdData[1:0] = {statusFlag, pending};
      A_KEY:   rdData[0]   = stopped;
      A_LIVE:  rdData      = liveMain;
      default: rdData      = '0;
    endcase
  end
endmodule

// File: rtl/wdog_dp.sv
module wdog_dp
  import wdog_pkg::*;
#(
  parameter int DW       = 8,
  parameter int PRE_DEF  = 255,
  parameter int MAIN_DEF = 255
) (
  input  logic          clk,
  input  logic          rstN,
  input  wdStrobe_t     strb,
  input  logic          tickIn,
  input  logic [DW-1:0] prescVal,
  input  logic [DW-1:0] preRl,
  input  logic [DW-1:0] mainRl,
  output logic          expire,
  output logic          resetReq,
  output logic [DW-1:0] liveMain
);
  logic [DW-1:0] pscCnt, preCnt, mainCnt;
  logic srcTick, step, pscWrap, mainStep;

  assign srcTick  = strb.useTick ? tickIn : 1'b1;
  assign step     = strb.run && !strb.load && srcTick;
  assign pscWrap  = step && (pscCnt == prescVal);
  assign mainStep = pscWrap && (preCnt == '0);
  assign expire   = mainStep && (mainCnt == DW'(1));
  assign liveMain = mainCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pscCnt   <= '0;
      preCnt   <= DW'(PRE_DEF);
      mainCnt  <= DW'(MAIN_DEF);
      resetReq <= 1'b0;
    end else begin
      resetReq <= expire;
      if (strb.load) begin
        pscCnt  <= '0;
        preCnt  <= preRl;
        mainCnt <= mainRl;
      end else if (step) begin
        pscCnt <= pscWrap ? '0 : pscCnt + 1'b1;
        if (pscWrap) preCnt <= (preCnt == '0) ? preRl : preCnt - 1'b1;
        if (mainStep && (mainCnt != '0)) mainCnt <= mainCnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int DW       = 8,
  parameter int PRE_DEF  = 255,
  parameter int MAIN_DEF = 255
) (
  input  logic          clk,
  input  logic          porRst_n,
  input  logic          sysRst_n,
  input  logic          wrEn,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wrData,
  input  logic          tickIn,
  output logic [DW-1:0] rdData,
  output logic          resetReq,
  output logic          rstStatus
);
  wdStrobe_t     strb;
  logic [DW-1:0] prescVal, preRl, mainRl, liveMain;
  logic          expire, stopped, pending, rstN;

  assign rstN = sysRst_n & porRst_n;

  wdog_ctrl #(.DW(DW), .PRE_DEF(PRE_DEF), .MAIN_DEF(MAIN_DEF)) u_ctrl (
    .clk(clk), .rstN(rstN), .porRst_n(porRst_n), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .expire(expire), .liveMain(liveMain), .strb(strb),
    .prescVal(prescVal), .preRl(preRl), .mainRl(mainRl), .stopped(stopped),
    .pending(pending), .statusFlag(rstStatus), .rdData(rdData)
  );

  wdog_dp #(.DW(DW), .PRE_DEF(PRE_DEF), .MAIN_DEF(MAIN_DEF)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .tickIn(tickIn), .prescVal(prescVal),
    .preRl(preRl), .mainRl(mainRl), .expire(expire), .resetReq(resetReq),
    .liveMain(liveMain)
  );
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk
  import wdog_pkg::*;
#(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          porRst_n,
  input logic          sysRst_n,
  input logic          wrEn,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] wrData,
  input logic          resetReq,
  input logic          rstStatus,
  input logic          stopped,
  input logic          pending,
  input logic [DW-1:0] prescVal
);
  // R7
  req_single_chk: assert property (@(posedge clk) disable iff (!porRst_n || !sysRst_n)
    resetReq |=> !resetReq);

  // R8
  req_sets_status_chk: assert property (@(posedge clk) disable iff (!porRst_n || !sysRst_n)
    resetReq |-> rstStatus);

  // R8
  status_sticky_chk: assert property (@(posedge clk) disable iff (!porRst_n)
    (rstStatus && !(wrEn && addr == A_CTRL && wrData[1])) |=> rstStatus);

  // R8
  status_clear_chk: assert property (@(posedge clk) disable iff (!porRst_n || !sysRst_n)
    (wrEn && addr == A_CTRL && wrData[1]) |=> (!rstStatus || resetReq));

  // R2
  halt_needs_key_chk: assert property (@(posedge clk) disable iff (!porRst_n || !sysRst_n)
    $rose(stopped) |-> $past(wrEn && addr == A_KEY && wrData == DW'(8'h63)));

  // R4
  cfg_locked_chk: assert property (@(posedge clk) disable iff (!porRst_n || !sysRst_n)
    (!stopped && wrEn && addr == A_PSC) |=> $stable(prescVal));

  // R5
  pend_set_chk: assert property (@(posedge clk) disable iff (!porRst_n || !sysRst_n)
    (wrEn && addr == A_CTRL && wrData[0]) |=> pending);

  // R5
  pend_clear_chk: assert property (@(posedge clk) disable iff (!porRst_n || !sysRst_n)
    (pending && !(wrEn && addr == A_CTRL && wrData[0])) |=> !pending);

  // R10
  halted_quiet_chk: assert property (@(posedge clk) disable iff (!porRst_n || !sysRst_n)
    stopped |=> !resetReq);
endmodule

bind wdog_timer wdog_chk #(.DW(DW)) u_chk (
  .clk(clk), .porRst_n(porRst_n), .sysRst_n(sysRst_n), .wrEn(wrEn), .addr(addr),
  .wrData(wrData), .resetReq(resetReq), .rstStatus(rstStatus), .stopped(stopped),
  .pending(pending), .prescVal(prescVal)
);

// File: tb/sim_wdog_timer.sv
`timescale 1ns/1ps
module sim_wdog_timer;
  logic       clk = 1'b0;
  logic       porRst_n = 1'b0, sysRst_n = 1'b0;
  logic       wrEn = 1'b0, tickIn = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       resetReq, rstStatus;

  int nChk = 0, nFail = 0, pulseCnt = 0, tcnt = 0;
  bit chkOn = 0, tickEn = 0;

  // behavioural model state
  int mCfg, mPresc, mPreRl, mMainRl, mPsc, mPre, mMain, mSeq;
  bit mStop, mPend, mStat, mReq;

  always #2.5 clk = ~clk;

  wdog_timer u0 (.clk(clk), .porRst_n(porRst_n), .sysRst_n(sysRst_n), .wrEn(wrEn),
    .addr(addr), .wrData(wrData), .tickIn(tickIn), .rdData(rdData),
    .resetReq(resetReq), .rstStatus(rstStatus));

  function automatic int keyByte(input int s);
    return (s == 0) ? 'h87 : (s == 1) ? 'h61 : 'h63;
  endfunction

  function automatic int mRead(input int a);
    case (a)
      0: return mCfg;
      1: return mPresc;
      2: return mPreRl;
      3: return mMainRl;
      4: return mStat * 2 + mPend;
      5: return mStop;
      6: return mMain;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin : model
    int nPsc, nPre, nMain;
    bit ex, rl, tk;
    if (!porRst_n || !sysRst_n) begin
      mCfg = 0; mPresc = 0; mPreRl = 255; mMainRl = 255;
      mPsc = 0; mPre = 255; mMain = 255; mSeq = 0;
      mStop = 0; mPend = 0; mReq = 0;
      if (!porRst_n) mStat = 0;
    end else begin
      nPsc = mPsc; nPre = mPre; nMain = mMain; ex = 0;
      tk = (mCfg != 0) ? tickIn : 1'b1;
      if (mPend) begin
        nPsc = 0; nPre = mPreRl; nMain = mMainRl;
      end else if (!mStop && tk) begin
        if (mPsc == mPresc) begin
          nPsc = 0;
          if (mPre == 0) begin
            nPre = mPreRl;
            if (mMain != 0) begin nMain = mMain - 1; ex = (mMain == 1); end
          end else nPre = mPre - 1;
        end else nPsc = (mPsc + 1) % 256;
      end
      mReq = ex;
      if (ex) mStat = 1;
      else if (wrEn && addr == 4 && wrData[1]) mStat = 0;
      rl = wrEn && addr == 4 && wrData[0];
      if (wrEn && mStop) begin
        case (addr)
          0: mCfg = wrData[0];
          1: mPresc = wrData;
          2: mPreRl = wrData;
          3: mMainRl = wrData;
          default: ;
        endcase
      end
      if (wrEn) begin
        if (addr == 5 && wrData == keyByte(mSeq)) begin
          if (mSeq == 2) begin mSeq = 0; mStop = 1; end else mSeq = mSeq + 1;
        end else mSeq = 0;
      end
      if (rl) mStop = 0;
      mPend = rl;
      mPsc = nPsc; mPre = nPre; mMain = nMain;
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    tcnt = tcnt + 1;
    tickIn = tickEn && (tcnt % 4 == 0);
    if (resetReq) pulseCnt++;
    if (chkOn) begin
      chk("R7 resetReq vs model", resetReq, mReq);
      chk("R8 rstStatus vs model", rstStatus, mStat);
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wrEn = 1'b1; addr = 3'(a); wrData = 8'(d);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdChk(input int a, input string tag);
    addr = 3'(a);
    #1;
    chk(tag, rdData, mRead(a));
  endtask

  task automatic unlock();
    wr(5, 'h87); wr(5, 'h61); wr(5, 'h63);
  endtask

  task automatic firstPulse(input int lim, output int idx);
    idx = 0;
    for (int i = 1; i <= lim; i++) begin
      @(negedge clk);
      if (resetReq && idx == 0) idx = i;
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", nFail, nChk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL timeout across R1..R10 actual=hung expected=done");
    finishRun();
  end

  initial begin
    int idx, base, v;
    repeat (3) @(negedge clk);
    porRst_n = 1'b1; sysRst_n = 1'b1;
    #1 chkOn = 1;
    // R1 reset state
    for (int a = 0; a < 8; a++) rdChk(a, "R1 reset read");
    chk("R1 running after reset", rdData, 0);
    // R3 broken sequences, R4 ignored config write
    wr(5, 'h87); wr(5, 'h61); wr(5, 'h00);
    rdChk(5, "R3 wrong byte"); chk("R3 still running", rdData[0], 0);
    wr(5, 'h87); wr(0, 1); wr(5, 'h61); wr(5, 'h63);
    rdChk(5, "R3 stray write"); chk("R3 still running", rdData[0], 0);
    wr(1, 5); rdChk(1, "R4 locked presc"); chk("R4 presc ignored", rdData, 0);
    rdChk(0, "R4 locked cfg");
    // R2 proper key
    unlock(); rdChk(5, "R2 halted"); chk("R2 halted", rdData[0], 1);
    // R5 / R6 fastest forced reset
    wr(2, 0); wr(3, 1); rdChk(3, "R4 main reload");
    wr(4, 1);
    rdChk(4, "R5 pending"); chk("R5 pending high", rdData[0], 1);
    chk("R6 no early req", resetReq, 0);
    @(negedge clk); #1 chk("R5 pending cleared", rdData[0], 0);
    rdChk(5, "R5 running again");
    @(negedge clk); chk("R6 req due", resetReq, 1);
    @(negedge clk); chk("R7 single cycle", resetReq, 0);
    chk("R8 status set", rstStatus, 1);
    base = pulseCnt; repeat (30) @(negedge clk);
    chk("R7 no repeat", pulseCnt - base, 0);
    // R8 clear, stickiness
    wr(4, 2); chk("R8 cleared", rstStatus, 0);
    wr(4, 1); repeat (3) @(negedge clk); chk("R8 set again", rstStatus, 1);
    chkOn = 0; sysRst_n = 1'b0; repeat (2) @(negedge clk); sysRst_n = 1'b1;
    #1 chk("R8 survives system reset", rstStatus, 1);
    chkOn = 1;
    for (int a = 0; a < 7; a++) rdChk(a, "R1 after system reset");
    @(negedge clk);
    chkOn = 0; porRst_n = 1'b0; repeat (2) @(negedge clk); porRst_n = 1'b1;
    #1 chk("R8 power-on clears", rstStatus, 0);
    chkOn = 1;
    // R6 prescaler chain: 3*2*2 = 12 ticks
    unlock(); wr(1, 2); wr(2, 1); wr(3, 2); wr(4, 1);
    firstPulse(20, idx); chk("R6 prescaled expiry", idx, 13);
    // R6 tick source
    unlock(); wr(0, 1); wr(1, 0); wr(2, 0); wr(3, 3); rdChk(0, "R6 cfg source");
    tickEn = 1; base = pulseCnt; wr(4, 1);
    firstPulse(40, idx);
    chk("R6 tick-source window", (idx >= 9 && idx <= 16), 1);
    chk("R6 tick-source one pulse", pulseCnt - base, 1);
    // R9 zero config restores clock source
    tickEn = 0; unlock(); wr(0, 0); rdChk(0, "R9 cfg default");
    wr(3, 1); wr(4, 1);
    firstPulse(6, idx); chk("R9 clock source back", idx, 2);
    // R10 halted holds
    unlock(); wr(3, 200); wr(4, 1); repeat (5) @(negedge clk);
    unlock(); rdChk(6, "R10 live count"); v = rdData;
    base = pulseCnt; repeat (20) @(negedge clk);
    rdChk(6, "R10 live held"); chk("R10 count frozen", rdData, v);
    chk("R10 no req", pulseCnt - base, 0);
    // R7 main reload of zero
    wr(3, 0); wr(4, 1); base = pulseCnt; repeat (60) @(negedge clk);
    chk("R7 zero never expires", pulseCnt - base, 0);
    rdChk(6, "R7 zero live");
    // R5 refresh keeps it alive (12 ticks period, refresh every 8)
    unlock(); wr(2, 3); wr(3, 3); wr(4, 1); base = pulseCnt;
    for (int k = 0; k < 6; k++) begin repeat (6) @(negedge clk); wr(4, 1); end
    chk("R5 refresh holds off", pulseCnt - base, 0);
    repeat (20) @(negedge clk);
    chk("R6 expiry after refresh stops", pulseCnt - base, 1);
    repeat (2) @(negedge clk);
    finishRun();
  end
endmodule